// File: doc/BRIEF.md
# Buffered Crossbar Cell Switch with Distributed Weighted Schedulers

This block is an N-by-N cell switch. The default is N = 4. A small FIFO sits at every crossing of an input row and an output column. Each input presents the head cell of N per-output virtual queues. The queue storage itself lives upstream of the block, and the switch only pops heads. A cell is one data word, and one clock cycle is one cell time.

Every input has its own weighted round-robin server. In each cycle that server takes at most one head cell from a queue whose crosspoint FIFO has room, and writes it into that FIFO. Every output has its own weighted round-robin server, which drains at most one non-empty FIFO of its column per cycle onto a registered output link. The input servers and output servers have no central matcher. They are coupled only through the fill level of each crosspoint, and a crosspoint depth of a single cell still works.

Each server gives every one of its flows a credit counter, loaded from that flow's weight. A flow with no credit left is passed over. When no requesting flow holds credit, all credits of that server reload at once. Under saturation this shares a port's cell slots in proportion to the weights. Weights come from static configuration inputs.

Top module: `xbar_switch`

## Requirements
- R1: During reset and in the first cycle after it, with no queue valid, every bit of `out_valid` and `in_pop` is 0.
- R2: For each input i, at most one bit of `in_pop[i*N +: N]` is 1 in any cycle. The head of queue (i,j) is consumed at the rising edge that ends a cycle in which `in_pop[i*N+j]` is 1.
- R3: An input never pops a cell toward a crosspoint that already holds DEPTH cells. A crosspoint count never exceeds DEPTH. The cells popped but not yet delivered for one input/output pair never exceed DEPTH+1.
- R4: Cells of every input/output pair leave in the order they were popped, and none is lost or duplicated. `out_src[j*IW +: IW]` carries the input index, and `out_data[j*DW +: DW]` carries the cell word.
- R5: Suppose the crosspoint is empty and the output is idle, and `voq_valid[i*N+j]` rises for cycle c. Then `in_pop[i*N+j]` is 1 in cycle c, and the cell shows on output j with `out_valid[j]` = 1 in cycle c+2 and not in cycle c+1.
- R6: With all inputs saturated towards one output, output j delivers cells from input k in proportion to the weight `out_wt[(j*N+k)*WW +: WW]`, within 6 cells over 840 cycles.
- R7: With one input saturated towards all outputs, input i sends cells of flow (i,j) in proportion to the weight `in_wt[(i*N+j)*WW +: WW]`, within 6 cells over 840 cycles.
- R8: A weight field of 0 is handled exactly like a weight of 1.
- R9: `out_valid[j]` is 1 only if column j held at least one cell in the previous cycle. After all traffic has drained, `out_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cell time per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| voq_valid | input | N*N | Bit i*N+j: queue of input i towards output j has a head cell |
| voq_data | input | N*N*DW | Head cell word of queue (i,j) at bits (i*N+j)*DW |
| in_pop | output | N*N | Bit i*N+j: head of queue (i,j) is taken at this edge |
| in_wt | input | N*N*WW | Input i weight for flow to output j at bits (i*N+j)*WW |
| out_wt | input | N*N*WW | Output j weight for flow from input k at bits (j*N+k)*WW |
| out_valid | output | N | Output j carries a cell this cycle |
| out_data | output | N*DW | Cell word on output j |
| out_src | output | N*IW | Input index of the cell on output j, IW = clog2(N) |

## Verification
The `in_pop` grant is combinational. The bench samples it at the falling edge of the same cycle in which a queue turns valid, and advances its queue model just after the following rising edge. A delivered cell passes two registers, the crosspoint FIFO and the output stage. For that reason the latency test looks for silence one cycle after the pop, the cell two cycles after it, and silence again in the third cycle. The monitor reads every output at falling edges against a per-pair sequence model. Share counts are taken over a fixed window that opens after a warm-up long enough for every crosspoint to fill, and each run ends with a drain period before loss is checked.

// File: rtl/xbar_pkg.sv
// Package: shared helpers for the buffered crossbar.
// Assumes flows are numbered source-major: flow = src*N + dst.
package xbar_pkg;

    // Flat flow index of an input/output pair.
    function automatic int flow_of(input int src, input int dst, input int n);
        return src * n + dst;
    endfunction

endpackage

// File: rtl/xp_fifo.sv
// Module: crosspoint cell FIFO.
// Holds up to DEPTH cells between one input and one output. A push and a pop
// in the same cycle leave the count unchanged. Full and non-empty come from
// the registered count. Assumes the caller never pushes when full and never
// pops when empty.
module xp_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic          full,
    output logic          nonempty,
    output logic [CW-1:0] count
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full     = (cnt == CW'(DEPTH));
    assign nonempty = (cnt != '0);
    assign rdata    = mem[rp];
    assign count    = cnt;

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= nxt(wp);
            if (pop)  rp <= nxt(rp);
            if (push && !pop)      cnt <= cnt + 1'b1;
            else if (!push && pop) cnt <= cnt - 1'b1;
        end
    end

    // Cell storage write.
    always_ff @(posedge clk) begin
        if (push) mem[wp] <= wdata;
    end

endmodule

// File: rtl/wrr_arb.sv
// Module: weighted round-robin server for one port.
// Every requester owns a credit counter loaded from its weight (0 counts
// as 1). A requester without credit is skipped. When no requester holds
// credit, all credits reload in that same cycle, so no slot is lost. The
// grant is combinational, and the search starts after the last winner.
module wrr_arb #(
    parameter int N  = 4,
    parameter int WW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic [N*WW-1:0] wt,
    output logic [N-1:0]  gnt
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [WW-1:0] credit [N];
    logic [WW-1:0] wt_e   [N];
    logic [WW-1:0] eff    [N];
    logic [N-1:0]  has_cr, elig;
    logic          reload, found;
    logic [IW-1:0] ptr, win;

    // Effective weights, credit state and the reload decision.
    always_comb begin
        for (int k = 0; k < N; k++) begin
            wt_e[k]   = (wt[k*WW +: WW] == '0) ? WW'(1) : wt[k*WW +: WW];
            has_cr[k] = (credit[k] != '0);
        end
        reload = (|req) && !(|(req & has_cr));
        for (int k = 0; k < N; k++) eff[k] = reload ? wt_e[k] : credit[k];
        elig = reload ? req : (req & has_cr);
    end

    // Rotating search for the first eligible requester from the pointer.
    always_comb begin
        found = 1'b0;
        win   = ptr;
        gnt   = '0;
        for (int k = 0; k < N; k++) begin
            int t;
            t = int'(ptr) + k;
            if (t >= N) t = t - N;
            if (!found && elig[t]) begin
                found = 1'b1;
                win   = IW'(t);
            end
        end
        if (found) gnt[win] = 1'b1;
    end

    // Credit consumption, reload and pointer advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < N; k++) credit[k] <= '0;
            ptr <= '0;
        end else begin
            if (reload) for (int k = 0; k < N; k++) credit[k] <= wt_e[k];
            if (found) begin
                credit[win] <= eff[win] - 1'b1;
                ptr <= (win == IW'(N - 1)) ? '0 : win + 1'b1;
            end
        end
    end

endmodule

// File: rtl/xbar_switch.sv
// Module: N x N buffered crossbar with per-port weighted servers.
// One crosspoint FIFO per input/output pair. Each input server sends at most
// one head cell per cycle to a crosspoint with room. Each output server
// drains at most one non-empty crosspoint of its column into a registered
// output. The only coupling between the two sides is crosspoint occupancy.
// Assumes the upstream queues hold voq_data stable until in_pop.
module xbar_switch
    import xbar_pkg::*;
#(
    parameter int N     = 4,
    parameter int DEPTH = 4,
    parameter int DW    = 8,
    parameter int WW    = 4,
    localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N*N-1:0]    voq_valid,
    input  logic [N*N*DW-1:0] voq_data,
    output logic [N*N-1:0]    in_pop,
    input  logic [N*N*WW-1:0] in_wt,
    input  logic [N*N*WW-1:0] out_wt,
    output logic [N-1:0]      out_valid,
    output logic [N*DW-1:0]   out_data,
    output logic [N*IW-1:0]   out_src
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [N*N-1:0]    xp_push, xp_pop, xp_full, xp_ne;
    logic [N*N*DW-1:0] xp_rdata;
    logic [N*N*CW-1:0] xp_cnt;
    logic [N-1:0]      col_ne  [N];
    logic [N-1:0]      col_gnt [N];
    logic [N-1:0]      col_any;

    assign in_pop = xp_push;

    genvar i, j;
    generate
        for (i = 0; i < N; i++) begin : g_row
            for (j = 0; j < N; j++) begin : g_col
                xp_fifo #(.DW(DW), .DEPTH(DEPTH)) u_xp (
                    .clk      (clk),
                    .rst_n    (rst_n),
                    .push     (xp_push[i*N+j]),
                    .wdata    (voq_data[(i*N+j)*DW +: DW]),
                    .pop      (xp_pop[i*N+j]),
                    .rdata    (xp_rdata[(i*N+j)*DW +: DW]),
                    .full     (xp_full[i*N+j]),
                    .nonempty (xp_ne[i*N+j]),
                    .count    (xp_cnt[(i*N+j)*CW +: CW])
                );
                assign col_ne[j][i]   = xp_ne[i*N+j];
                assign xp_pop[i*N+j]  = col_gnt[j][i];
            end

            wrr_arb #(.N(N), .WW(WW)) u_in_srv (
                .clk   (clk),
                .rst_n (rst_n),
                .req   (voq_valid[i*N +: N] & ~xp_full[i*N +: N]),
                .wt    (in_wt[i*N*WW +: N*WW]),
                .gnt   (xp_push[i*N +: N])
            );
        end

        for (j = 0; j < N; j++) begin : g_out
            logic [IW-1:0] win;
            logic [DW-1:0] wdat;
            logic          v_q;
            logic [DW-1:0] d_q;
            logic [IW-1:0] s_q;

            wrr_arb #(.N(N), .WW(WW)) u_out_srv (
                .clk   (clk),
                .rst_n (rst_n),
                .req   (col_ne[j]),
                .wt    (out_wt[j*N*WW +: N*WW]),
                .gnt   (col_gnt[j])
            );

            assign col_any[j] = |col_ne[j];

            // Select the granted crosspoint's head cell and its source.
            always_comb begin
                win  = '0;
                wdat = '0;
                for (int k = 0; k < N; k++) begin
                    if (col_gnt[j][k]) begin
                        win  = IW'(k);
                        wdat = xp_rdata[flow_of(k, j, N)*DW +: DW];
                    end
                end
            end

            // Output link register.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    v_q <= 1'b0;
                    d_q <= '0;
                    s_q <= '0;
                end else begin
                    v_q <= |col_gnt[j];
                    if (|col_gnt[j]) begin
                        d_q <= wdat;
                        s_q <= win;
                    end
                end
            end

            assign out_valid[j]          = v_q;
            assign out_data[j*DW +: DW]  = d_q;
            assign out_src[j*IW +: IW]   = s_q;
        end
    endgenerate

endmodule

// File: rtl/xbar_switch_chk.sv
// Module: property checker for xbar_switch, attached by bind.
// Watches the pops, the crosspoint counts and the outputs.
module xbar_switch_chk #(
    parameter int N     = 4,
    parameter int DEPTH = 4,
    parameter int CW    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N*N-1:0]   in_pop,
    input logic [N*N-1:0]   xp_pop,
    input logic [N*N*CW-1:0] xp_cnt,
    input logic [N-1:0]     out_valid,
    input logic [N-1:0]     col_any
);
    // R1: outputs start idle when reset is released.
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (out_valid == '0));

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_port
            // R2: one pop per input per cycle.
            p_one_pop_r2: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(in_pop[g*N +: N]));
            // R9: an output cell needs a filled column one cycle earlier.
            p_out_needs_cell_r9: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid[g] |-> $past(col_any[g]));
        end
        for (g = 0; g < N*N; g++) begin : g_flow
            // R3: never push into a full crosspoint.
            p_no_push_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
                in_pop[g] |-> (xp_cnt[g*CW +: CW] < CW'(DEPTH)));
            // R3: count stays within depth.
            p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
                xp_cnt[g*CW +: CW] <= CW'(DEPTH));
            // R4: a lone push grows the count by one.
            p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (in_pop[g] && !xp_pop[g]) |=>
                    (xp_cnt[g*CW +: CW] == CW'($past(xp_cnt[g*CW +: CW]) + 1'b1)));
        end
    endgenerate

endmodule

bind xbar_switch xbar_switch_chk #(.N(N), .DEPTH(DEPTH), .CW(CW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_pop    (in_pop),
    .xp_pop    (xp_pop),
    .xp_cnt    (xp_cnt),
    .out_valid (out_valid),
    .col_any   (col_any)
);

// File: tb/test_xbar_switch.sv
// Bench: upstream queue model, output monitor, a share-vector table and
// directed tests for reset, latency and drain.
module test_xbar_switch;
    localparam int CLK_PERIOD = 10;
    localparam int N     = 4;
    localparam int DEPTH = 4;
    localparam int DW    = 8;
    localparam int WW    = 4;
    localparam int IW    = 2;
    localparam int NF    = N * N;
    localparam int WARM  = 40;
    localparam int WIN   = 840;
    localparam int DRAIN = 60;
    localparam int TOL   = 6;
    localparam int SAT   = 1 << 30;
    // Row: mode (0 = all inputs to output 0, 1 = input 0 to all outputs), w0..w3.
    localparam int NV = 5;
    localparam logic [16:0] VEC [NV] = '{
        {1'b0, 4'd1, 4'd2, 4'd3, 4'd4},
        {1'b0, 4'd4, 4'd1, 4'd1, 4'd2},
        {1'b0, 4'd2, 4'd2, 4'd2, 4'd2},
        {1'b1, 4'd1, 4'd1, 4'd2, 4'd4},
        {1'b1, 4'd0, 4'd3, 4'd0, 4'd4}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NF-1:0]     voq_valid;
    logic [NF*DW-1:0]  voq_data;
    logic [NF-1:0]     in_pop;
    logic [NF*WW-1:0]  in_wt, out_wt;
    logic [N-1:0]      out_valid;
    logic [N*DW-1:0]   out_data;
    logic [N*IW-1:0]   out_src;

    int tx_seq [NF];
    int rx_seq [NF];
    int rx_cnt [NF];
    int budget [NF];
    int order_err = 0, infl_err = 0, pop_err = 0;
    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xbar_switch #(.N(N), .DEPTH(DEPTH), .DW(DW), .WW(WW)) i_xbar_switch (
        .clk(clk), .rst_n(rst_n), .voq_valid(voq_valid), .voq_data(voq_data),
        .in_pop(in_pop), .in_wt(in_wt), .out_wt(out_wt),
        .out_valid(out_valid), .out_data(out_data), .out_src(out_src)
    );

    // Queue heads follow the model's budgets and sequence numbers.
    always_comb begin
        for (int f = 0; f < NF; f++) begin
            voq_valid[f]             = (budget[f] > 0);
            voq_data[f*DW +: DW]     = tx_seq[f][DW-1:0];
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor and queue model: sample at falling edge, advance after rising edge.
    initial begin
        logic [NF-1:0] p;
        for (int f = 0; f < NF; f++) begin
            tx_seq[f] = 0; rx_seq[f] = 0; rx_cnt[f] = 0; budget[f] = 0;
        end
        forever begin
            @(negedge clk);
            p = in_pop;
            for (int i = 0; i < N; i++)
                if ($countones(p[i*N +: N]) > 1) pop_err++;
            for (int j = 0; j < N; j++) begin
                if (out_valid[j] && rst_n) begin
                    int f;
                    f = int'(out_src[j*IW +: IW]) * N + j;
                    if (out_data[j*DW +: DW] != rx_seq[f][DW-1:0]) order_err++;
                    rx_seq[f]++;
                    rx_cnt[f]++;
                end
            end
            for (int f = 0; f < NF; f++)
                if (tx_seq[f] - rx_seq[f] > DEPTH + 1) infl_err++;
            @(posedge clk);
            #1;
            for (int f = 0; f < NF; f++)
                if (p[f]) begin
                    tx_seq[f]++;
                    budget[f]--;
                end
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        in_wt  = {NF{4'd1}};
        out_wt = {NF{4'd1}};
        // R1: idle during reset.
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == '0 && in_pop == '0, "R1 in reset", int'(out_valid), 0);
        @(posedge clk); #2; rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == '0, "R1 out_valid after reset", int'(out_valid), 0);
        chk(in_pop == '0, "R1 in_pop after reset", int'(in_pop), 0);

        // R5: single cell on pair (1,2), flow 6.
        @(posedge clk); #2; budget[6] = 1;
        @(negedge clk);
        chk(in_pop[6] == 1'b1, "R5 pop in request cycle", int'(in_pop[6]), 1);
        @(negedge clk);
        chk(out_valid[2] == 1'b0, "R5 no output at c+1", int'(out_valid[2]), 0);
        @(negedge clk);
        chk(out_valid[2] == 1'b1, "R5 output at c+2", int'(out_valid[2]), 1);
        chk(out_src[2*IW +: IW] == 2'd1, "R4 source index", int'(out_src[2*IW +: IW]), 1);
        chk(out_data[2*DW +: DW] == 8'd0, "R4 cell word", int'(out_data[2*DW +: DW]), 0);
        @(negedge clk);
        chk(out_valid == '0, "R9 idle after single cell", int'(out_valid), 0);

        // Share vectors, R6 (mode 0) and R7 (mode 1), with R8 zero weights.
        for (int v = 0; v < NV; v++) begin
            int w [N];
            int base [N];
            int sum;
            bit mode;
            mode = VEC[v][16];
            sum = 0;
            for (int k = 0; k < N; k++) begin
                w[k] = int'(VEC[v][15-4*k -: 4]);
                sum += (w[k] == 0) ? 1 : w[k];
            end
            @(posedge clk); #2;
            in_wt  = {NF{4'd1}};
            out_wt = {NF{4'd1}};
            order_err = 0; infl_err = 0;
            for (int k = 0; k < N; k++) begin
                if (!mode) begin
                    out_wt[k*WW +: WW] = WW'(w[k]);
                    budget[k*N] = SAT;
                end else begin
                    in_wt[k*WW +: WW] = WW'(w[k]);
                    budget[k] = SAT;
                end
            end
            repeat (WARM) @(posedge clk);
            #2;
            for (int k = 0; k < N; k++) base[k] = rx_cnt[mode ? k : k*N];
            repeat (WIN) @(posedge clk);
            #2;
            for (int k = 0; k < N; k++) begin
                int got, exp, we;
                we  = (w[k] == 0) ? 1 : w[k];
                exp = WIN * we / sum;
                got = rx_cnt[mode ? k : k*N] - base[k];
                chk(got >= exp - TOL && got <= exp + TOL,
                    mode ? ((w[k] == 0) ? "R7 R8 input share" : "R7 input share")
                         : "R6 output share", got, exp);
            end
            for (int f = 0; f < NF; f++) budget[f] = 0;
            repeat (DRAIN) @(posedge clk);
            @(negedge clk);
            begin
                int lost;
                lost = 0;
                for (int f = 0; f < NF; f++) lost += tx_seq[f] - rx_seq[f];
                chk(lost == 0, "R4 no loss after drain", lost, 0);
            end
            chk(order_err == 0, "R4 per-pair order", order_err, 0);
            chk(infl_err == 0, "R3 cells in flight bound", infl_err, 0);
            chk(out_valid == '0, "R9 idle after drain", int'(out_valid), 0);
        end

        chk(pop_err == 0, "R2 one pop per input", pop_err, 0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule